// File: doc/BRIEF.md
# Glitch-Free Selectable Card Clock Divider

This block produces the clock for a contact card from a fast reference clock. A two-bit select input picks one of four division ratios. The fastest ratio still holds each output level for a configurable number of reference cycles, `HALF_BASE`. The slower ratios hold each level two, four or eight times as long. The output is a registered square wave. A ratio change is only ever applied at a rising edge of the output, after a complete low phase. As a result, every high and every low pulse has the full width of the ratio it belongs to, and no runt pulse can appear.

An enable input, driven by the card activation sequencer, gates the output. While enable is low and the divider is idle, the output rests low. When enable is deasserted mid-run, the high phase in progress and the low phase after it both run to completion before the divider stops. The select input comes from another clock domain. It is resynchronised through two flops. If both select bits are seen to change at once, the value is treated as unsettled: the previous ratio stays in force for one full output period, after which the select is sampled again. The undivided reference is also brought out, so that a host can drive the card clock directly.

Top module: `card_clk_divider`

## Requirements
- R1: After reset, and for as long as enable has not been asserted, `card_clk` is low.
- R2: The select code sets the length of each output phase. With the fastest phase equal to `HALF_BASE` (default 8) reference cycles, the phase lengths are: `00` = 8×`HALF_BASE` (divide by 8), `01` = 4×`HALF_BASE` (divide by 4), `11` = 2×`HALF_BASE` (divide by 2), `10` = `HALF_BASE` (divide by 1).
- R3: A new ratio takes effect only at a rising edge of `card_clk` that ends a complete low phase. The high and low phases before that edge keep the old length, and those after it have the new length, whether the ratio is getting faster or slower.
- R4: No high or low phase of `card_clk` is ever shorter than `HALF_BASE` reference cycles.
- R5: When the divider is idle and `clk_en` is sampled high, `card_clk` rises on the next reference edge and starts a full-length high phase. No rising edge happens unless enable was high.
- R6: When `clk_en` is deasserted, the current high phase and the following low phase finish at full length. After that, `card_clk` stays low and no further rising edge occurs.
- R7: A select change is picked up two reference cycles after it arrives. A change of exactly one bit is adopted at once. A change of both bits leaves the previous ratio in force for 2×(current phase length) reference cycles; after that wait, the settled select is adopted.
- R8: `ref_clk_out` carries `clk_ref` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 2 | Division ratio select (encoding in R2) |
| clk_en | input | 1 | Clock enable from the activation sequencer |
| card_clk | output | 1 | Divided, gated card clock |
| ref_clk_out | output | 1 | Undivided reference clock |

## Verification
The assertions assume that `clk_en` and `div_sel` are stable across each reference edge. They also assume that a ratio change normally flips a single select bit, and that a two-bit flip is a rare event that gets resolved by waiting. The stimulus keeps to these assumptions. It drives every input on the falling reference edge, and it moves between the four ratios along the one-bit-apart order 00, 01, 11, 10, with a single deliberate two-bit jump from 01 to 10 used to exercise the wait. The mid-run changes are timed shortly after a rising edge of `card_clk`. This gives the synchroniser time to settle well before the low phase that follows ends, so the expected switch point is known exactly.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

    // Select codes follow a one-bit-apart order across the four ratios.
    typedef enum logic [1:0] {
        SEL_DIV8 = 2'b00,
        SEL_DIV4 = 2'b01,
        SEL_DIV2 = 2'b11,
        SEL_DIV1 = 2'b10
    } div_sel_e;

    // Length of one output phase, in reference cycles, for a select code.
    function automatic int unsigned half_len(div_sel_e s, int unsigned base);
        case (s)
            SEL_DIV1: return base;
            SEL_DIV2: return base * 2;
            SEL_DIV4: return base * 4;
            default:  return base * 8;
        endcase
    endfunction

    // True when both select bits moved at once.
    function automatic logic both_bits_moved(logic [1:0] a, logic [1:0] b);
        return (a ^ b) == 2'b11;
    endfunction

endpackage

// File: rtl/ccd_sync.sv
module ccd_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/ccd_sel_ctrl.sv
module ccd_sel_ctrl #(
    parameter int CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           sel_s,
    input  logic [CNT_W-1:0]     half_cur,
    output ccd_pkg::div_sel_e    sel_ok
);
    import ccd_pkg::*;

    logic [1:0]       sel_prev;
    logic             hold;
    logic [CNT_W-1:0] hold_cnt;
    logic [CNT_W-1:0] hold_load;

    // One full period of the ratio currently running, minus one.
    always_comb hold_load = (half_cur << 1) - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_prev <= SEL_DIV8;
            sel_ok   <= SEL_DIV8;
            hold     <= 1'b0;
            hold_cnt <= '0;
        end else begin
            sel_prev <= sel_s;
            if (sel_s != sel_prev) begin
                if (both_bits_moved(sel_s, sel_prev) || hold) begin
                    hold     <= 1'b1;
                    hold_cnt <= hold_load;
                end else begin
                    sel_ok <= div_sel_e'(sel_s);
                end
            end else if (hold) begin
                if (hold_cnt == '0) begin
                    hold   <= 1'b0;
                    sel_ok <= div_sel_e'(sel_s);
                end else begin
                    hold_cnt <= hold_cnt - CNT_W'(1);
                end
            end
        end
    end

    // R7: the adopted ratio stays frozen while a two-bit change is waiting.
    a_r7_hold_freezes: assert property (@(posedge clk) disable iff (rst)
        hold |-> $stable(sel_ok));
endmodule

// File: rtl/ccd_gen.sv
module ccd_gen #(
    parameter int HALF_BASE = 8,
    parameter int CNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  ccd_pkg::div_sel_e sel_ok,
    output logic              card_clk,
    output logic [CNT_W-1:0]  half_cur
);
    import ccd_pkg::*;

    logic             running;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_next;
    logic             phase_end;

    always_comb half_next = CNT_W'(half_len(sel_ok, HALF_BASE));
    always_comb phase_end = (cnt == half_cur - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            running  <= 1'b0;
            card_clk <= 1'b0;
            cnt      <= '0;
            half_cur <= CNT_W'(half_len(SEL_DIV8, HALF_BASE));
        end else if (!running) begin
            cnt <= '0;
            if (en) begin
                running  <= 1'b1;
                card_clk <= 1'b1;
                half_cur <= half_next;
            end
        end else if (phase_end) begin
            cnt <= '0;
            if (card_clk) begin
                card_clk <= 1'b0;
            end else if (en) begin
                card_clk <= 1'b1;
                half_cur <= half_next;
            end else begin
                running <= 1'b0;
            end
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R5: a rising edge needs enable sampled high.
    a_r5_rise_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(card_clk) |-> $past(en));

    // R3: the phase length only changes together with a rising edge.
    a_r3_commit_at_rise: assert property (@(posedge clk) disable iff (rst)
        !$stable(half_cur) |-> $rose(card_clk));

    // R6: the divider only stops after enable was dropped.
    a_r6_stop_needs_disable: assert property (@(posedge clk) disable iff (rst)
        $fell(running) |-> !$past(en));

    // R4: the phase counter never runs past the current phase length.
    a_r4_count_in_range: assert property (@(posedge clk) disable iff (rst)
        running |-> cnt < half_cur);
endmodule

// File: rtl/card_clk_divider.sv
module card_clk_divider #(
    parameter int HALF_BASE = 8
) (
    input  logic       clk_ref,
    input  logic       rst,
    input  logic [1:0] div_sel,
    input  logic       clk_en,
    output logic       card_clk,
    output logic       ref_clk_out
);
    import ccd_pkg::*;

    localparam int CNT_W = $clog2(HALF_BASE * 16 + 1);

    logic [1:0]       sel_s;
    div_sel_e         sel_ok;
    logic [CNT_W-1:0] half_cur;

    assign ref_clk_out = clk_ref;

    ccd_sync #(.W(2)) u_sync (
        .clk (clk_ref),
        .rst (rst),
        .d   (div_sel),
        .q   (sel_s)
    );

    ccd_sel_ctrl #(.CNT_W(CNT_W)) u_sel (
        .clk      (clk_ref),
        .rst      (rst),
        .sel_s    (sel_s),
        .half_cur (half_cur),
        .sel_ok   (sel_ok)
    );

    ccd_gen #(.HALF_BASE(HALF_BASE), .CNT_W(CNT_W)) u_gen (
        .clk      (clk_ref),
        .rst      (rst),
        .en       (clk_en),
        .sel_ok   (sel_ok),
        .card_clk (card_clk),
        .half_cur (half_cur)
    );
endmodule

// File: tb/tb_card_clk_divider.sv
module tb_card_clk_divider;
    localparam int HB = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] div_sel = 2'b00;
    logic       clk_en = 1'b0;
    logic       card_clk;
    logic       ref_clk_out;

    card_clk_divider #(.HALF_BASE(HB)) dut (
        .clk_ref     (clk),
        .rst         (rst),
        .div_sel     (div_sel),
        .clk_en      (clk_en),
        .card_clk    (card_clk),
        .ref_clk_out (ref_clk_out)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic  lvl;
        int    len;     // 0: open-ended, only the minimum is checked
        string req;
    } phase_t;

    phase_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int rises  = 0;
    logic cur_lvl = 1'b0;
    int   run_len = 0;
    bit   done = 0;

    function automatic int half_of(logic [1:0] s);
        case (s)
            2'b10:   return HB;
            2'b11:   return HB * 2;
            2'b01:   return HB * 4;
            default: return HB * 8;
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push(logic lvl, int len, string req);
        phase_t p;
        p.lvl = lvl; p.len = len; p.req = req;
        exp_q.push_back(p);
    endtask

    task automatic push_periods(logic [1:0] s, int n, string req);
        for (int i = 0; i < n; i++) begin
            push(1'b1, half_of(s), req);
            push(1'b0, half_of(s), req);
        end
    endtask

    task automatic wait_rises(int n);
        wait (rises >= n);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: measures each completed phase and compares with the queue.
    always @(negedge clk) begin
        if (!done) begin
            if (card_clk === cur_lvl) begin
                run_len++;
            end else begin
                if (exp_q.size() == 0) begin
                    check(0, "R6", "unexpected phase end, length", run_len, 0);
                end else begin
                    phase_t p;
                    p = exp_q.pop_front();
                    check(cur_lvl == p.lvl, p.req, "phase level", int'(cur_lvl), int'(p.lvl));
                    if (p.len == 0)
                        check(run_len >= HB, "R4", "open phase length", run_len, HB);
                    else
                        check(run_len == p.len, p.req, "phase length", run_len, p.len);
                end
                if (card_clk === 1'b1) rises++;
                cur_lvl = card_clk;
                run_len = 1;
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        int r0;
        push(1'b0, 0, "R1");
        // R1: low during reset and while enable is low
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(card_clk == 1'b0, "R1", "card_clk in reset", int'(card_clk), 0);
        end
        rst = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (i % 10 == 0)
                check(card_clk == 1'b0, "R1", "card_clk disabled", int'(card_clk), 0);
        end
        // R8: reference passes through
        @(posedge clk); #5;
        check(ref_clk_out == 1'b1, "R8", "ref_clk_out high", int'(ref_clk_out), 1);
        @(negedge clk); #5;
        check(ref_clk_out == 1'b0, "R8", "ref_clk_out low", int'(ref_clk_out), 0);
        @(negedge clk);

        // R2/R5/R6: divide by 8, two periods, disable mid high phase
        r0 = rises;
        push_periods(2'b00, 1, "R2");
        push(1'b1, half_of(2'b00), "R6");
        push(1'b0, 0, "R6");
        clk_en = 1'b1;
        wait_rises(r0 + 2);
        clk_en = 1'b0;
        idle(300);

        // R3: speed up mid-run 01 -> 11 -> 10, then stop
        div_sel = 2'b01;
        idle(10);
        r0 = rises;
        push_periods(2'b01, 1, "R3");
        push_periods(2'b11, 2, "R3");
        push_periods(2'b10, 2, "R3");
        push(1'b1, half_of(2'b10), "R6");
        push(1'b0, 0, "R6");
        clk_en = 1'b1;
        wait_rises(r0 + 1);
        div_sel = 2'b11;
        wait_rises(r0 + 3);
        div_sel = 2'b10;
        wait_rises(r0 + 6);
        clk_en = 1'b0;
        idle(100);

        // R3: slow down mid-run 10 -> 00
        r0 = rises;
        push_periods(2'b10, 1, "R3");
        push_periods(2'b00, 1, "R3");
        push(1'b1, half_of(2'b00), "R6");
        push(1'b0, 0, "R6");
        clk_en = 1'b1;
        wait_rises(r0 + 1);
        div_sel = 2'b00;
        wait_rises(r0 + 3);
        clk_en = 1'b0;
        idle(300);

        // R7: two-bit jump 01 -> 10 waits one period (phase 64 -> 128 cycles)
        div_sel = 2'b01;
        idle(10);
        div_sel = 2'b10;
        idle(9);
        r0 = rises;
        push_periods(2'b01, 2, "R7");
        push_periods(2'b10, 1, "R7");
        push(1'b1, half_of(2'b10), "R6");
        push(1'b0, 0, "R6");
        clk_en = 1'b1;
        wait_rises(r0 + 4);
        clk_en = 1'b0;
        idle(200);

        check(exp_q.size() == 1, "R6", "pending phases after stop", exp_q.size(), 1);
        check(card_clk == 1'b0, "R6", "card_clk after stop", int'(card_clk), 0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "R5", "watchdog expired, cycles", 100000, 0);
        finish_run();
    end
endmodule